// File: doc/BRIEF.md
# PRBS Receive Lane Checker with Half-Word Alignment

This block checks one recovered parallel lane of a serial link that carries a pseudo-random test pattern. Each clock it takes a 20-bit word from the deserializer and a one-bit alignment indicator. The word is made of two 10-bit halves. When the indicator reports that the halves arrived in the wrong order, the block exchanges them. The corrected word goes into a register.

The block then hunts for the first word of the test sequence. When it sees that word, it declares the lane valid and starts a local reference generator. From then on every received word is compared against the word the reference predicts. A per-lane match output can drive an indicator lamp directly. Any mismatch after lock sets a sticky error flag and raises a saturating 16-bit error count. A synchronous reset returns the lane to the search state and clears the flag and the count.

Top module: `prbs_rx_checker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `lane_valid`, `lane_match` and `err_flag` are 0 and `err_count` is 0.
- R2: When `rx_swap` is 1, bits [19:10] and [9:0] of `rx_word` change places before the word is used. When it is 0, the word is used as received. The indicator is sampled with its own word.
- R3: Before lock, `lane_valid` is 0, `lane_match` is 0 for any word other than the first sequence word, and the error flag and count do not change.
- R4: When the aligned word equals the first sequence word while searching, `lane_valid` and `lane_match` both become 1.
- R5: The sequence comes from a 31-bit shift register seeded with 31'h12345678. For each bit, the new bit is state[30] XOR state[27]; the state shifts left and takes the new bit at bit 0. Twenty bits are produced per word, with the first bit in word bit 19. After the first word, the next received word is checked against the second word, and so on.
- R6: While locked, `lane_match` is 1 exactly when the aligned word equals the expected word. `lane_match` is never 1 while `lane_valid` is 0.
- R7: Each mismatched word while locked sets `err_flag`, which then stays 1 until reset, and adds one to `err_count`.
- R8: Once `lane_valid` is 1 it stays 1 until reset. A later copy of the first sequence word does not restart the search. It is compared like any other word.
- R9: `err_count` stops at 65535 and does not wrap.
- R10: A word captured at rising edge k affects `lane_valid`, `lane_match`, `err_flag` and `err_count` from rising edge k+1 on. Asserting `rst` clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 20 | Received word as two 10-bit halves |
| rx_swap | input | 1 | 1 = halves arrived exchanged |
| lane_match | output | 1 | Last compared word agreed with the reference |
| lane_valid | output | 1 | Sequence start found; lane locked |
| err_flag | output | 1 | Sticky: a mismatch was seen after lock |
| err_count | output | 16 | Saturating count of mismatches after lock |

## Verification
A reference generator that is one step off, or a lock that loads the wrong state, shows up within one clock of lock. It drops `lane_match` and raises `err_count` on the very first compared word. A lock state that falls back to searching shows up as `lane_valid` going low one clock after a mismatch. A half-exchange that is reversed means the swapped stream never locks, so `lane_valid` stays low for the whole run. A count that wraps is visible at the 65536th mismatch, when it reads zero instead of 65535.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;

    localparam int LFSR_W     = 31;
    localparam int TAP_HI     = 30;
    localparam int TAP_LO     = 27;
    localparam int WORD_W     = 20;
    localparam int NUM_HALVES = 2;
    localparam int HALF_W     = WORD_W / NUM_HALVES;
    localparam int CNT_W_DEF  = 16;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam lfsr_t SEED_DEF = 31'h1234_5678;

    // One parallel step of the pattern source: the register after
    // WORD_W shifts and the word those shifts emitted.
    typedef struct packed {
        lfsr_t state;
        word_t word;
    } prbs_step_t;

    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_LOCKED = 1'b1
    } lock_e;

    typedef struct packed {
        logic hit_first;
        logic hit_ref;
    } cmp_res_t;

    // The earliest generated bit lands in the most significant word bit.
    function automatic prbs_step_t prbs_advance(input lfsr_t s);
        prbs_step_t r;
        logic       fb;
        r.state = s;
        r.word  = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb         = r.state[TAP_HI] ^ r.state[TAP_LO];
            r.state    = {r.state[LFSR_W-2:0], fb};
            r.word[i]  = fb;
        end
        return r;
    endfunction

endpackage

// File: rtl/prbs_half_align.sv
module prbs_half_align
    import prbs_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t din,
    input  logic  swap,
    output word_t dout
);

    word_t fixed;

    // Each output half picks its mirror half when the indicator is set.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam int SRC = NUM_HALVES - 1 - h;
        assign fixed[h*HALF_W +: HALF_W] = swap ? din[SRC*HALF_W +: HALF_W]
                                                : din[h*HALF_W +: HALF_W];
    end

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= fixed;
    end

    AST_SWAP_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        swap |=> dout[HALF_W-1:0] == $past(din[WORD_W-1:HALF_W])); // R2
    AST_SWAP_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
        swap |=> dout[WORD_W-1:HALF_W] == $past(din[HALF_W-1:0])); // R2
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !swap |=> dout == $past(din)); // R2

endmodule

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
    import prbs_rx_pkg::*;
#(
    parameter lfsr_t SEED = SEED_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  adv,
    output word_t exp_word
);

    localparam prbs_step_t FIRST_STEP = prbs_advance(SEED);

    lfsr_t      st;
    prbs_step_t nxt;

    always_comb nxt = prbs_advance(st);
    assign exp_word = nxt.word;

    // On load the register takes the state after the first word, so the
    // word it offers next is the second one of the sequence.
    always_ff @(posedge clk) begin
        if (rst || load) st <= FIRST_STEP.state;
        else if (adv)    st <= nxt.state;
    end

    AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && adv)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(exp_word)); // R5

endmodule

// File: rtl/prbs_lock_cmp.sv
module prbs_lock_cmp
    import prbs_rx_pkg::*;
#(
    parameter lfsr_t SEED = SEED_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t aligned,
    input  word_t expected,
    output logic  load,
    output logic  adv,
    output logic  miss,
    output logic  valid,
    output logic  match
);

    localparam prbs_step_t FIRST_STEP = prbs_advance(SEED);
    localparam word_t      FIRST_WORD = FIRST_STEP.word;

    lock_e    st, st_n;
    cmp_res_t cmp;

    always_comb begin
        cmp.hit_first = (aligned == FIRST_WORD);
        cmp.hit_ref   = (aligned == expected);
        st_n = st;
        load = 1'b0;
        adv  = 1'b0;
        miss = 1'b0;
        case (st)
            LK_SEARCH: begin
                if (cmp.hit_first) begin
                    load = 1'b1;
                    st_n = LK_LOCKED;
                end
            end
            LK_LOCKED: begin
                adv  = 1'b1;
                miss = !cmp.hit_ref;
            end
            default: st_n = LK_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= LK_SEARCH;
            match <= 1'b0;
        end else begin
            st    <= st_n;
            match <= (st == LK_SEARCH) ? cmp.hit_first : cmp.hit_ref;
        end
    end

    assign valid = (st == LK_LOCKED);

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid); // R8
    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        match |-> valid); // R6
    AST_LOCK_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!valid && aligned == FIRST_WORD) |=> (valid && match)); // R4

endmodule

// File: rtl/prbs_err_tally.sv
module prbs_err_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss,
    output logic             flag,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            cnt  <= '0;
        end else if (miss) begin
            flag <= 1'b1;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (miss && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R9
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !miss |=> $stable(cnt) && $stable(flag)); // R3

endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker
    import prbs_rx_pkg::*;
#(
    parameter lfsr_t SEED  = SEED_DEF,
    parameter int    CNT_W = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_swap,
    output logic              lane_match,
    output logic              lane_valid,
    output logic              err_flag,
    output logic [CNT_W-1:0]  err_count
);

    word_t aligned_q;
    word_t exp_word;
    logic  ld_ref;
    logic  step_ref;
    logic  miss;

    prbs_half_align u_align (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_word),
        .swap (rx_swap),
        .dout (aligned_q)
    );

    prbs_ref_gen #(.SEED(SEED)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_ref),
        .adv      (step_ref),
        .exp_word (exp_word)
    );

    prbs_lock_cmp #(.SEED(SEED)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .aligned  (aligned_q),
        .expected (exp_word),
        .load     (ld_ref),
        .adv      (step_ref),
        .miss     (miss),
        .valid    (lane_valid),
        .match    (lane_match)
    );

    prbs_err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk  (clk),
        .rst  (rst),
        .miss (miss),
        .flag (err_flag),
        .cnt  (err_count)
    );

    AST_NO_ERR_SEARCH: assert property (@(posedge clk) disable iff (rst)
        !lane_valid |=> $stable(err_count)); // R3
    AST_FLAG_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> lane_valid); // R7

endmodule

// File: tb/tb_prbs_rx_checker.sv
`timescale 1ns/1ps
module tb_prbs_rx_checker;

    localparam logic [30:0] TB_SEED = 31'h1234_5678;
    localparam int          CMAX    = 65535;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] rx_word = '0;
    logic        rx_swap = 1'b0;
    logic        lane_match, lane_valid, err_flag;
    logic [15:0] err_count;

    int checks = 0;
    int errors = 0;
    logic [30:0] gen_st;

    // expectation pipeline: a word driven now is visible two samples later
    bit    p1_on, p2_on;
    bit    p1_m, p1_v, p1_f, p2_m, p2_v, p2_f;
    int    p1_c, p2_c;
    string p1_r, p2_r;

    always #2.5 clk = ~clk;

    prbs_rx_checker dut (
        .clk(clk), .rst(rst), .rx_word(rx_word), .rx_swap(rx_swap),
        .lane_match(lane_match), .lane_valid(lane_valid),
        .err_flag(err_flag), .err_count(err_count)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    // pattern source written from the R5 definition
    function automatic logic [19:0] gen_next();
        logic [19:0] w;
        logic        b;
        w = '0;
        for (int i = 19; i >= 0; i--) begin
            b      = gen_st[30] ^ gen_st[27];
            gen_st = {gen_st[29:0], b};
            w[i]   = b;
        end
        return w;
    endfunction

    task automatic cyc(input logic [19:0] w, input logic sw, input bit on,
                       input bit m, input bit v, input bit f, input int c,
                       input string r);
        @(negedge clk);
        if (p2_on) begin
            chk(p2_r, "lane_match", int'(lane_match), int'(p2_m));
            chk(p2_r, "lane_valid", int'(lane_valid), int'(p2_v));
            chk(p2_r, "err_flag",   int'(err_flag),   int'(p2_f));
            chk(p2_r, "err_count",  int'(err_count),  p2_c);
        end
        p2_on = p1_on; p2_m = p1_m; p2_v = p1_v; p2_f = p1_f; p2_c = p1_c; p2_r = p1_r;
        p1_on = on;    p1_m = m;    p1_v = v;    p1_f = f;    p1_c = c;    p1_r = r;
        rx_word = sw ? {w[9:0], w[19:10]} : w;
        rx_swap = sw;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_word = '0; rx_swap = 1'b0;
        p1_on = 0; p2_on = 0;
        repeat (3) @(negedge clk);
        chk("R10", "valid in reset", int'(lane_valid), 0);
        chk("R10", "count in reset", int'(err_count), 0);
        rst = 1'b0;
        gen_st = TB_SEED;
    endtask

    task automatic drain(input logic sw);
        cyc(gen_next(), sw, 0, 0, 0, 0, 0, "");
        cyc(gen_next(), sw, 0, 0, 0, 0, 0, "");
        cyc(gen_next(), sw, 0, 0, 0, 0, 0, "");
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "lane_valid", int'(lane_valid), 0);
        chk("R1", "lane_match", int'(lane_match), 0);
        chk("R1", "err_flag",   int'(err_flag),   0);
        chk("R1", "err_count",  int'(err_count),  0);
    endtask

    // mode 0: straight, 1: all exchanged, 2: indicator alternates per word
    task automatic t_lock(input int mode);
        logic [19:0] w0;
        logic        sw;
        string       tag;
        do_reset();
        w0 = gen_next();
        gen_st = TB_SEED;
        tag = (mode == 0) ? "R6" : "R2";
        for (int i = 0; i < 4; i++) begin
            sw = (mode == 1) || (mode == 2 && i[0]);
            cyc(w0 ^ 20'(i + 1), sw, 1, 0, 0, 0, 0, "R3");
        end
        for (int i = 0; i < 12; i++) begin
            sw = (mode == 1) || (mode == 2 && i[0]);
            cyc(gen_next(), sw, 1, 1, 1, 0, 0, (i == 0) ? "R4" : ((i == 1) ? "R5" : tag));
        end
        drain(mode == 1);
    endtask

    task automatic t_errors();
        logic [19:0] w0, w;
        int c;
        do_reset();
        c = 0;
        cyc(20'h0F0F0, 0, 1, 0, 0, 0, 0, "R3");
        for (int i = 0; i < 12; i++) begin
            w = gen_next();
            if (i == 0) w0 = w;
            if (i == 6) begin
                c++;
                cyc(w ^ 20'h00400, 0, 1, 0, 1, 1, c, "R7");
            end else if (i == 9) begin
                c++;
                cyc(w0, 0, 1, 0, 1, 1, c, "R8");
            end else begin
                cyc(w, 0, 1, 1, 1, (c > 0), c, (c > 0) ? "R7" : "R6");
            end
        end
        drain(0);
    endtask

    task automatic t_saturate();
        logic [19:0] w;
        do_reset();
        cyc(gen_next(), 0, 1, 1, 1, 0, 0, "R4");
        for (int i = 1; i <= CMAX + 4; i++) begin
            w = gen_next();
            if (i >= CMAX - 1)
                cyc(~w, 0, 1, 0, 1, 1, (i > CMAX) ? CMAX : i, "R9");
            else
                cyc(~w, 0, 0, 0, 0, 0, 0, "");
        end
        cyc(~gen_next(), 0, 0, 0, 0, 0, 0, "");
        cyc(~gen_next(), 0, 0, 0, 0, 0, 0, "");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10", "err_flag after reset",  int'(err_flag),  0);
        chk("R10", "err_count after reset", int'(err_count), 0);
        chk("R10", "lane_valid after reset", int'(lane_valid), 0);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lock(0);
        t_lock(1);
        t_lock(2);
        t_errors();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule